// File: doc/BRIEF.md
# PC Card Memory Lane Steering Decoder

This block is the control decoder of a linear flash memory card. It sits between a 16-bit PC Card host bus and an array of byte-wide flash devices that are grouped in pairs, one device on the low (even) byte lane and one on the high (odd) byte lane. Each pair holds 1 MB. The decoder samples the host address, the two active-low card enables, the read and write strobes, the attribute-space select and the write-protect switch on each clock edge. It then drives the per-pair chip selects, the attribute EEPROM select, the gated device write strobe, the address bits shared by all devices, and the enables and crossover control of the bidirectional data buffers.

The crossover control lets an 8-bit host reach every byte on the low lanes. In that mode the host uses the least significant address bit to pick the odd or the even byte. Card density is a static input from 1 to 10 pairs. Addresses above the density wrap at the next power-of-two boundary. Any address that still lands above the populated pairs after wrapping selects nothing.

Top module: `pcl_lane_steer`

## Requirements
- R1: While rst_n is low, and on the first output after it, every chip select and attr_cs_n is high, dev_we_n is high, lane_lo_oe, lane_hi_oe and lane_swap are 0, and dev_addr is 0.
- R2: All outputs are registered. A set of inputs sampled on one rising edge is reflected on the outputs right after that edge. With ce1_n and ce2_n both high (standby), no chip select or attr_cs_n is asserted, dev_we_n is high and both lane enables are 0.
- R3: Word access (ce1_n=0, ce2_n=0) selects both the low and the high device of the addressed pair, whatever host_addr[0] is. A read drives both lanes, and lane_swap is 0.
- R4: Byte access (ce1_n=0, ce2_n=1) selects only the low device when host_addr[0]=0, and only the high device with lane_swap=1 when host_addr[0]=1. A read drives only the low lanes.
- R5: Odd-only access (ce1_n=1, ce2_n=0) selects only the high device. A read drives only the high lanes, and lane_swap is 0.
- R6: The pair index is host_addr[23:20] after wrapping, and bit p of cs_lo_n and cs_hi_n belongs to pair p. dev_addr equals host_addr[19:1]. At most one bit of each chip-select vector is low.
- R7: The pair field wraps modulo 1, 2, 4, 4, 8, 8, 8, 8, 16 and 16 for densities 1 to 10. Host address bits 24 and up never affect the result.
- R8: A wrapped index that is not below the density selects no pair. A density above 10 acts as 10, and a density of 0 selects no pair.
- R9: With reg_n=0, no flash chip select is asserted. attr_cs_n goes low only when the even byte is addressed: word access, or byte access with host_addr[0]=0.
- R10: With wp=1, dev_we_n stays high for any write with reg_n=1. Attribute-space writes still pass.
- R11: The lane enables are asserted only when oe_n=0 and we_n=1 in the same sample. Any low write strobe keeps both lanes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| density | input | 4 | Number of populated 1 MB pairs (1 to 10) |
| host_addr | input | 26 | Host byte address |
| ce1_n | input | 1 | Even-lane card enable, active low |
| ce2_n | input | 1 | Odd-lane card enable, active low |
| oe_n | input | 1 | Host read strobe, active low |
| we_n | input | 1 | Host write strobe, active low |
| reg_n | input | 1 | Attribute-space select, active low |
| wp | input | 1 | Write-protect switch, high blocks flash writes |
| dev_addr | output | 19 | Address bits 19..1 shared by all flash devices |
| cs_lo_n | output | 10 | Per-pair low-lane device selects, active low |
| cs_hi_n | output | 10 | Per-pair high-lane device selects, active low |
| attr_cs_n | output | 1 | Attribute EEPROM select, active low |
| dev_we_n | output | 1 | Gated write strobe to the memories, active low |
| lane_lo_oe | output | 1 | Drive host D7-D0 |
| lane_hi_oe | output | 1 | Drive host D15-D8 |
| lane_swap | output | 1 | Cross the high device byte onto the low host lanes |

## Verification
The read-lane enables and the write strobe can be requested in the same cycle when the host pulls oe_n and we_n low together. The bench issues such samples for word, byte and odd-only accesses, with wp both set and clear. The scoreboard expects both lanes to be off, and it expects dev_we_n to follow only the write-protect and attribute-space rules. Wrap and density cut-off also apply in one cycle, so addresses are picked to land above the populated pairs only after wrapping.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

   typedef enum logic [2:0] {
      ACC_IDLE     = 3'd0,
      ACC_WORD     = 3'd1,
      ACC_BYTE_EVN = 3'd2,
      ACC_BYTE_ODD = 3'd3,
      ACC_ODD_ONLY = 3'd4
   } acc_kind_e;

   typedef struct packed {
      logic lo_sel;
      logic hi_sel;
      logic swap;
      logic any_ce;
   } lane_sel_t;

endpackage

// File: rtl/pcl_access_decode.sv
module pcl_access_decode
   import pcl_pkg::*;
(
   input  logic      ce1_n,
   input  logic      ce2_n,
   input  logic      a0,
   input  logic      oe_n,
   input  logic      we_n,
   input  logic      reg_n,
   input  logic      wp,
   output acc_kind_e kind,
   output lane_sel_t sel,
   output logic      lane_lo_oe,
   output logic      lane_hi_oe,
   output logic      dev_we_n,
   output logic      attr_cs_n
);

   logic read_act;
   logic write_ok;

   always_comb begin
      unique case ({ce2_n, ce1_n})
         2'b00:   kind = ACC_WORD;
         2'b10:   kind = a0 ? ACC_BYTE_ODD : ACC_BYTE_EVN;
         2'b01:   kind = ACC_ODD_ONLY;
         default: kind = ACC_IDLE;
      endcase
   end

   always_comb begin
      sel = '0;
      unique case (kind)
         ACC_WORD:     begin sel.lo_sel = 1'b1; sel.hi_sel = 1'b1; end
         ACC_BYTE_EVN: sel.lo_sel = 1'b1;
         ACC_BYTE_ODD: begin sel.hi_sel = 1'b1; sel.swap = 1'b1; end
         ACC_ODD_ONLY: sel.hi_sel = 1'b1;
         default:      sel = '0;
      endcase
      sel.any_ce = (kind != ACC_IDLE);
   end

   assign read_act   = sel.any_ce && !oe_n && we_n;
   assign lane_lo_oe = read_act && !ce1_n;
   assign lane_hi_oe = read_act && !ce2_n;

   assign write_ok   = !reg_n || !wp;
   assign dev_we_n   = !(sel.any_ce && !we_n && write_ok);

   assign attr_cs_n  = !(!reg_n && sel.lo_sel);

endmodule

// File: rtl/pcl_addr_wrap.sv
module pcl_addr_wrap #(
   parameter int unsigned N_PAIRS = 10,
   parameter int unsigned DENS_W  = 4,
   localparam int unsigned IDX_W  = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
   input  logic [DENS_W-1:0] density,
   input  logic [IDX_W-1:0]  raw_idx,
   output logic [IDX_W-1:0]  pair_idx,
   output logic              pair_hit
);

   logic [DENS_W-1:0] dens_eff;
   logic [IDX_W-1:0]  wrap_mask;

   always_comb begin
      if (int'(density) > int'(N_PAIRS))
         dens_eff = DENS_W'(N_PAIRS);
      else
         dens_eff = density;
   end

   always_comb begin
      wrap_mask = '0;
      for (int b = 0; b < int'(IDX_W); b++) begin
         if ((1 << b) < int'(dens_eff))
            wrap_mask = {wrap_mask[IDX_W-2:0], 1'b1};
      end
   end

   assign pair_idx = raw_idx & wrap_mask;
   assign pair_hit = int'(pair_idx) < int'(dens_eff);

endmodule

// File: rtl/pcl_pair_select.sv
module pcl_pair_select #(
   parameter int unsigned N_PAIRS = 10,
   localparam int unsigned IDX_W  = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
   input  logic [IDX_W-1:0]   pair_idx,
   input  logic               pair_hit,
   input  logic               common_space,
   input  logic               lo_sel,
   input  logic               hi_sel,
   output logic [N_PAIRS-1:0] cs_lo_n,
   output logic [N_PAIRS-1:0] cs_hi_n
);

   logic pair_en;
   assign pair_en = pair_hit && common_space;

   for (genvar p = 0; p < int'(N_PAIRS); p++) begin : g_pair
      logic hit_p;
      assign hit_p      = pair_en && (pair_idx == IDX_W'(p));
      assign cs_lo_n[p] = !(hit_p && lo_sel);
      assign cs_hi_n[p] = !(hit_p && hi_sel);
   end

endmodule

// File: rtl/pcl_lane_steer.sv
module pcl_lane_steer
   import pcl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 26,
   parameter int unsigned PAIR_LSB = 20,
   parameter int unsigned N_PAIRS  = 10,
   parameter int unsigned DENS_W   = 4,
   localparam int unsigned IDX_W   = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1,
   localparam int unsigned DEV_AW  = PAIR_LSB - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DENS_W-1:0]  density,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic               ce1_n,
   input  logic               ce2_n,
   input  logic               oe_n,
   input  logic               we_n,
   input  logic               reg_n,
   input  logic               wp,
   output logic [DEV_AW-1:0]  dev_addr,
   output logic [N_PAIRS-1:0] cs_lo_n,
   output logic [N_PAIRS-1:0] cs_hi_n,
   output logic               attr_cs_n,
   output logic               dev_we_n,
   output logic               lane_lo_oe,
   output logic               lane_hi_oe,
   output logic               lane_swap
);

   if (ADDR_W < PAIR_LSB + IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for pair index");
   end
   if ((1 << DENS_W) <= N_PAIRS) begin : g_bad_dens
      $error("DENS_W cannot encode N_PAIRS");
   end
   if (PAIR_LSB < 2) begin : g_bad_lsb
      $error("PAIR_LSB must leave device address bits");
   end

   if (ADDR_W > PAIR_LSB + IDX_W) begin : g_upper
      logic unused_upper;
      assign unused_upper = ^host_addr[ADDR_W-1:PAIR_LSB+IDX_W];
   end

   acc_kind_e          kind;
   lane_sel_t          sel;
   logic               lo_oe_c, hi_oe_c, we_n_c, attr_n_c;
   logic [IDX_W-1:0]   pair_idx;
   logic               pair_hit;
   logic [N_PAIRS-1:0] cs_lo_c, cs_hi_c;
   logic               unused_kind;

   assign unused_kind = ^kind;

   pcl_access_decode i_decode (
      .ce1_n      (ce1_n),
      .ce2_n      (ce2_n),
      .a0         (host_addr[0]),
      .oe_n       (oe_n),
      .we_n       (we_n),
      .reg_n      (reg_n),
      .wp         (wp),
      .kind       (kind),
      .sel        (sel),
      .lane_lo_oe (lo_oe_c),
      .lane_hi_oe (hi_oe_c),
      .dev_we_n   (we_n_c),
      .attr_cs_n  (attr_n_c)
   );

   pcl_addr_wrap #(.N_PAIRS(N_PAIRS), .DENS_W(DENS_W)) i_wrap (
      .density  (density),
      .raw_idx  (host_addr[PAIR_LSB +: IDX_W]),
      .pair_idx (pair_idx),
      .pair_hit (pair_hit)
   );

   pcl_pair_select #(.N_PAIRS(N_PAIRS)) i_pairs (
      .pair_idx     (pair_idx),
      .pair_hit     (pair_hit),
      .common_space (reg_n),
      .lo_sel       (sel.lo_sel),
      .hi_sel       (sel.hi_sel),
      .cs_lo_n      (cs_lo_c),
      .cs_hi_n      (cs_hi_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_addr   <= '0;
         cs_lo_n    <= '1;
         cs_hi_n    <= '1;
         attr_cs_n  <= 1'b1;
         dev_we_n   <= 1'b1;
         lane_lo_oe <= 1'b0;
         lane_hi_oe <= 1'b0;
         lane_swap  <= 1'b0;
      end else begin
         dev_addr   <= host_addr[PAIR_LSB-1:1];
         cs_lo_n    <= cs_lo_c;
         cs_hi_n    <= cs_hi_c;
         attr_cs_n  <= attr_n_c;
         dev_we_n   <= we_n_c;
         lane_lo_oe <= lo_oe_c;
         lane_hi_oe <= hi_oe_c;
         lane_swap  <= sel.swap;
      end
   end

endmodule

// File: rtl/pcl_lane_steer_chk.sv
module pcl_lane_steer_chk #(
   parameter int unsigned ADDR_W   = 26,
   parameter int unsigned PAIR_LSB = 20,
   parameter int unsigned N_PAIRS  = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  host_addr,
   input logic               ce1_n,
   input logic               ce2_n,
   input logic               oe_n,
   input logic               we_n,
   input logic               reg_n,
   input logic               wp,
   input logic [PAIR_LSB-2:0] dev_addr,
   input logic [N_PAIRS-1:0] cs_lo_n,
   input logic [N_PAIRS-1:0] cs_hi_n,
   input logic               attr_cs_n,
   input logic               dev_we_n,
   input logic               lane_lo_oe,
   input logic               lane_hi_oe,
   input logic               lane_swap
);

   // R6: one pair at most per lane
   p_onehot_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_lo_n) && $onehot0(~cs_hi_n));

   p_addr_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> dev_addr == $past(host_addr[PAIR_LSB-1:1]));

   // R11: a write strobe never lets the lanes drive
   p_no_contend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(we_n) |-> !lane_lo_oe && !lane_hi_oe);

   // R10: flash writes blocked by the switch
   p_wp_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wp) && $past(reg_n) |-> dev_we_n);

   // R9: attribute space touches no flash pair
   p_attr_no_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(reg_n) |-> (&cs_lo_n) && (&cs_hi_n));

   // R2: standby keeps everything quiet
   p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce1_n) && $past(ce2_n) |->
         attr_cs_n && dev_we_n && !lane_lo_oe && !lane_hi_oe && (&cs_lo_n));

   // R4: crossover only with the high lanes idle
   p_swap_lo_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_swap |-> !lane_hi_oe && (&cs_lo_n));

endmodule

bind pcl_lane_steer pcl_lane_steer_chk #(
   .ADDR_W(ADDR_W), .PAIR_LSB(PAIR_LSB), .N_PAIRS(N_PAIRS)
) i_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
   .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
   .reg_n(reg_n), .wp(wp), .dev_addr(dev_addr),
   .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n), .attr_cs_n(attr_cs_n),
   .dev_we_n(dev_we_n), .lane_lo_oe(lane_lo_oe),
   .lane_hi_oe(lane_hi_oe), .lane_swap(lane_swap)
);

// File: tb/test_pcl_lane_steer.sv
`timescale 1ns/1ps
module test_pcl_lane_steer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  density = 4'd4;
   logic [25:0] host_addr = '0;
   logic        ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic        reg_n = 1'b1, wp = 1'b0;
   logic [18:0] dev_addr;
   logic [9:0]  cs_lo_n, cs_hi_n;
   logic        attr_cs_n, dev_we_n, lane_lo_oe, lane_hi_oe, lane_swap;

   int n_cmp = 0;
   int n_bad = 0;
   logic [43:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   pcl_lane_steer i_pcl_lane_steer (
      .clk(clk), .rst_n(rst_n), .density(density), .host_addr(host_addr),
      .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
      .reg_n(reg_n), .wp(wp), .dev_addr(dev_addr),
      .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n), .attr_cs_n(attr_cs_n),
      .dev_we_n(dev_we_n), .lane_lo_oe(lane_lo_oe),
      .lane_hi_oe(lane_hi_oe), .lane_swap(lane_swap)
   );

   function automatic logic [43:0] model(input logic [3:0] dens,
      input logic [25:0] a, input logic c1, input logic c2,
      input logic oe, input logic we, input logic rg, input logic pr);
      logic lo, hi, sw, rd, anyce, attr, wen;
      logic [9:0] lo_n, hi_n;
      int d, bound, idx;
      lo = 0; hi = 0; sw = 0;
      if (!c1 && !c2) begin lo = 1; hi = 1; end
      else if (!c1) begin
         if (a[0]) begin hi = 1; sw = 1; end else lo = 1;
      end
      else if (!c2) hi = 1;
      d = (dens > 10) ? 10 : int'(dens);
      case (d)
         0, 1: bound = 1;
         2: bound = 2;
         3, 4: bound = 4;
         5, 6, 7, 8: bound = 8;
         default: bound = 16;
      endcase
      idx = int'(a[25:20]) % bound;
      lo_n = '1; hi_n = '1;
      if (rg && idx < d) begin
         if (lo) lo_n[idx] = 1'b0;
         if (hi) hi_n[idx] = 1'b0;
      end
      attr  = !(!rg && lo);
      anyce = !c1 || !c2;
      rd    = !oe && we && anyce;
      wen   = !(!we && anyce && (!rg || !pr));
      return {a[19:1], lo_n, hi_n, attr, wen, rd && !c1, rd && !c2, sw};
   endfunction

   function automatic logic [43:0] observed();
      return {dev_addr, cs_lo_n, cs_hi_n, attr_cs_n, dev_we_n,
              lane_lo_oe, lane_hi_oe, lane_swap};
   endfunction

   task automatic drive(input string tag, input logic [3:0] dens,
      input logic [25:0] a, input logic c1, input logic c2,
      input logic oe, input logic we, input logic rg, input logic pr);
      @(negedge clk);
      density = dens; host_addr = a; ce1_n = c1; ce2_n = c2;
      oe_n = oe; we_n = we; reg_n = rg; wp = pr;
      exp_q.push_back(model(dens, a, c1, c2, oe, we, rg, pr));
      tag_q.push_back(tag);
   endtask

   // monitor: compare after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [43:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (observed() !== e) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", t, observed(), e);
            end
         end
      end
   end

   function automatic logic [25:0] ad(input int field, input int off);
      return {6'(field), 20'(off)};
   endfunction

   initial begin
      fork
         begin
            #400000;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      join_none

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      n_cmp++;
      if (observed() !== {19'h0, 10'h3ff, 10'h3ff, 1'b1, 1'b1, 3'b000}) begin
         n_bad++;
         $display("FAIL R1 reset: actual %h expected reset values", observed());
      end
      @(negedge clk);
      ce1_n = 0; ce2_n = 0; oe_n = 0;  // activity during reset must not leak
      @(posedge clk); #1;
      n_cmp++;
      if (observed() !== {19'h0, 10'h3ff, 10'h3ff, 1'b1, 1'b1, 3'b000}) begin
         n_bad++;
         $display("FAIL R1 reset hold: actual %h expected reset values", observed());
      end
      @(negedge clk);
      ce1_n = 1; ce2_n = 1; oe_n = 1;
      rst_n = 1'b1;

      // R2: standby
      drive("R2 standby rd", 4'd4, ad(1, 20'h12345), 1, 1, 0, 1, 1, 0);
      drive("R2 standby wr", 4'd4, ad(2, 20'h00010), 1, 1, 1, 0, 1, 0);
      // R3: word access, A0 ignored
      drive("R3 word a0=0", 4'd4, ad(2, 20'h0ABC4), 0, 0, 0, 1, 1, 0);
      drive("R3 word a0=1", 4'd4, ad(2, 20'h0ABC5), 0, 0, 0, 1, 1, 0);
      drive("R3 word write", 4'd4, ad(3, 20'hFFFFE), 0, 0, 1, 0, 1, 0);
      // R4: byte access
      drive("R4 byte even", 4'd4, ad(1, 20'h55554), 0, 1, 0, 1, 1, 0);
      drive("R4 byte odd", 4'd4, ad(1, 20'h55555), 0, 1, 0, 1, 1, 0);
      drive("R4 byte odd wr", 4'd4, ad(0, 20'h00001), 0, 1, 1, 0, 1, 0);
      // R5: odd-only
      drive("R5 odd only", 4'd4, ad(3, 20'h80000), 1, 0, 0, 1, 1, 0);
      drive("R5 odd only a0", 4'd4, ad(3, 20'h80001), 1, 0, 0, 1, 1, 0);
      // R6: index and device address
      drive("R6 addr pattern", 4'd10, ad(7, 20'hA5A5A), 0, 0, 0, 1, 1, 0);
      drive("R6 pair 9", 4'd10, ad(9, 20'h5A5A4), 0, 0, 0, 1, 1, 0);
      // R7: wrap
      drive("R7 dens3 wrap", 4'd3, ad(5, 20'h01000), 0, 0, 0, 1, 1, 0);
      drive("R7 dens1 wrap", 4'd1, ad(3, 20'h00002), 0, 0, 0, 1, 1, 0);
      drive("R7 dens5 wrap", 4'd5, ad(12, 20'h00000), 0, 0, 0, 1, 1, 0);
      drive("R7 dens10 hi bits", 4'd10, ad(6'h39, 20'h00100), 0, 0, 0, 1, 1, 0);
      drive("R7 dens2 wrap", 4'd2, ad(6'h3F, 20'h00006), 0, 1, 0, 1, 1, 0);
      // R8: beyond density
      drive("R8 dens3 gap", 4'd3, ad(7, 20'h00000), 0, 0, 0, 1, 1, 0);
      drive("R8 dens5 gap", 4'd5, ad(13, 20'h00000), 0, 0, 0, 1, 1, 0);
      drive("R8 dens9 gap", 4'd9, ad(9, 20'h00000), 0, 0, 0, 1, 1, 0);
      drive("R8 dens12 clamp", 4'd12, ad(10, 20'h00000), 0, 0, 0, 1, 1, 0);
      drive("R8 dens12 ok", 4'd12, ad(9, 20'h00000), 0, 0, 0, 1, 1, 0);
      drive("R8 dens0", 4'd0, ad(0, 20'h00000), 0, 0, 0, 1, 1, 0);
      // R9: attribute space
      drive("R9 attr even", 4'd4, ad(0, 20'h00040), 0, 1, 0, 1, 0, 0);
      drive("R9 attr odd", 4'd4, ad(0, 20'h00041), 0, 1, 0, 1, 0, 0);
      drive("R9 attr word", 4'd4, ad(1, 20'h00040), 0, 0, 0, 1, 0, 0);
      drive("R9 attr odd only", 4'd4, ad(0, 20'h00040), 1, 0, 0, 1, 0, 0);
      // R10: write protect
      drive("R10 wp word wr", 4'd4, ad(1, 20'h00100), 0, 0, 1, 0, 1, 1);
      drive("R10 wp byte wr", 4'd4, ad(2, 20'h00101), 0, 1, 1, 0, 1, 1);
      drive("R10 wp attr wr", 4'd4, ad(0, 20'h00000), 0, 1, 1, 0, 0, 1);
      drive("R10 no wp wr", 4'd4, ad(2, 20'h00100), 1, 0, 1, 0, 1, 0);
      // R11: read and write strobes together
      drive("R11 oe+we word", 4'd4, ad(1, 20'h00010), 0, 0, 0, 0, 1, 0);
      drive("R11 oe+we odd wp", 4'd4, ad(1, 20'h00011), 0, 1, 0, 0, 1, 1);
      drive("R11 oe+we odd only", 4'd4, ad(2, 20'h00010), 1, 0, 0, 0, 1, 0);
      drive("R11 no oe", 4'd4, ad(2, 20'h00010), 0, 0, 1, 1, 1, 0);
      drive("R2 back to idle", 4'd4, ad(0, 20'h00000), 1, 1, 1, 1, 1, 0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R2 pending: actual %0d left expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule